// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Core Reset Instruction

This block is a board-test access port driven entirely by the four serial test pins. A 16-state controller, stepped by the mode pin on each rising test-clock edge, moves between instruction scans and data scans. A 5-bit instruction register selects one of four data registers: a one-bit bypass cell, a 32-bit device identifier, a boundary chain of three cells per modelled pad, and a one-bit core-reset register. All state lives in the test-clock domain, so no system clock is needed.

The boundary chain sits between the core and a small set of pads. With the sample/preload instruction, the chain takes a snapshot of the pins and core drive values and can be preloaded, while the core keeps control of the pads. With the external-test instruction, the preloaded latches take over the pads the moment the instruction is updated. The core-reset instruction lets the tester hold the core in reset through its data register. That request is combined with an external active-low reset. While the core is held in reset, every pad enable is forced off unless external test owns the pads. This makes a separate high-impedance instruction unnecessary. The serial output is modelled as a data bit `tdo` plus an enable `tdo_en`: enable low stands for high impedance.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows the standard 16-state transitions on the mode input at each rising `tck`. Five consecutive rising edges with `tms`=1 reach Test-Logic-Reset from any state. One edge in Test-Logic-Reset restores the default instruction and clears the core-reset register.
- R2: In Test-Logic-Reset the instruction becomes IDCODE (binary 00001). A following data scan then shifts out the 32-bit identifier parameter, least significant bit first. The identifier has bit 0 equal to 1.
- R3: The instruction register is 5 bits wide. Capture-IR loads 00001, so the first five bits shifted out are 1,0,0,0,0. The opcodes are external test 00000, IDCODE 00001, sample/preload 00010, core reset 01100 and bypass 11111. Every other opcode selects the bypass cell.
- R4: Bypass is a single cell that captures 0. Data on `tdi` appears on `tdo` one shift later.
- R5: With sample/preload, Capture-DR loads the chain. For pad i, bit 3i holds `pad_in[i]`, bit 3i+1 holds `core_out[i]` and bit 3i+2 holds `core_oe[i]`; bit 0 is shifted out first. External test captures the same image. Update-DR loads the output and enable latches, but under sample/preload the pads keep following `core_out` and `core_oe`.
- R6: Under external test, `pad_out[i]` and `pad_oe[i]` come from the latches of chain bits 3i+1 and 3i+2. This takes effect on the Update-IR edge that loads the instruction and follows every later Update-DR.
- R7: The core-reset instruction selects a one-bit register that captures the held value. Its Update-DR value is held as a reset request. `core_reset` is high when this request is set or when `ext_rst_n` is low.
- R8: While `core_reset` is high and the instruction is not external test, every `pad_oe` bit is 0. Otherwise, outside external test, `pad_oe` equals `core_oe`.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly in the half-cycles that follow the Shift-IR and Shift-DR states, and is 0 otherwise.
- R10: `tap_rst`, sampled high on a rising `tck` edge, forces Test-Logic-Reset and clears the register state. The next falling edge drops `tdo_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all logic runs on it |
| tap_rst | input | 1 | Synchronous active-high test-logic reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when `tdo_en` is high |
| tdo_en | output | 1 | Serial output drive enable (low = high impedance) |
| ext_rst_n | input | 1 | External active-low core reset |
| core_reset | output | 1 | Active-high reset to the core |
| pad_in | input | NPADS | Values seen at the pins |
| core_out | input | NPADS | Core output values for the pads |
| core_oe | input | NPADS | Core output enables for the pads |
| pad_out | output | NPADS | Output value driven to each pad |
| pad_oe | output | NPADS | Output enable driven to each pad |

## Verification
Several properties are checked by assertions on every rising test-clock edge:
- five mode-high edges always end in Test-Logic-Reset;
- the instruction register changes only on Update-IR or in Test-Logic-Reset;
- the serial output enable tracks the shift states;
- an external reset always reaches `core_reset`;
- pad enables stay off while the core is held in reset outside external test;
- under sample/preload the pads follow the core.

Other behaviour only the scoreboard scenarios can show. These include the exact captured bit images and identifier value, the bypass one-bit delay, unused opcodes falling back to bypass, and the pads switching to the preloaded latches at the instruction update. They also include the falling-edge timing of `tdo` and the reset request surviving instruction changes until Test-Logic-Reset clears it.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int IR_W = 5;
    localparam int ID_W = 32;

    // Controller states; encoding is free, transitions are fixed
    typedef enum logic [3:0] {
        TS_RESET    = 4'h0,
        TS_IDLE     = 4'h1,
        TS_SEL_DR   = 4'h2,
        TS_CAP_DR   = 4'h3,
        TS_SHIFT_DR = 4'h4,
        TS_EXIT1_DR = 4'h5,
        TS_PAUSE_DR = 4'h6,
        TS_EXIT2_DR = 4'h7,
        TS_UPD_DR   = 4'h8,
        TS_SEL_IR   = 4'h9,
        TS_CAP_IR   = 4'hA,
        TS_SHIFT_IR = 4'hB,
        TS_EXIT1_IR = 4'hC,
        TS_PAUSE_IR = 4'hD,
        TS_EXIT2_IR = 4'hE,
        TS_UPD_IR   = 4'hF
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST   = 5'b00000;
    localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00001;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 5'b00010;
    localparam logic [IR_W-1:0] OP_CORE_RST = 5'b01100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;

    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_ID     = 2'd1,
        SEL_BSR    = 2'd2,
        SEL_RST    = 2'd3
    } dr_sel_e;

    typedef struct packed {
        logic    extest;
        logic    sample;
        logic    core_rst;
        dr_sel_e sel;
    } ir_decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   n = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   n = tms ? TS_SEL_DR   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    // Unlisted opcodes fall back to the bypass cell
    function automatic ir_decode_t ir_decode(input logic [IR_W-1:0] op);
        ir_decode_t d;
        d = '{extest: 1'b0, sample: 1'b0, core_rst: 1'b0, sel: SEL_BYPASS};
        case (op)
            OP_EXTEST:   begin d.extest   = 1'b1; d.sel = SEL_BSR; end
            OP_SAMPLE:   begin d.sample   = 1'b1; d.sel = SEL_BSR; end
            OP_IDCODE:   d.sel = SEL_ID;
            OP_CORE_RST: begin d.core_rst = 1'b1; d.sel = SEL_RST; end
            default:     d.sel = SEL_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // Run length of consecutive mode-high edges, saturating at five
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (rst || !tms)          ones_q <= 3'd0;
        else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
    end

    p_five_ones_r1: assert property (@(posedge tck) disable iff (rst)
        (ones_q == 3'd5) |-> (state == TS_RESET));

    p_leave_reset_r1: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET && !tms) |=> (state == TS_IDLE));

endmodule

// File: rtl/bscan_tap_ir.sv
module bscan_tap_ir
    import bscan_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] shreg;

    always_ff @(posedge tck) begin
        if (rst) begin
            shreg <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            case (state)
                TS_CAP_IR:   shreg <= IR_CAPTURE;
                TS_SHIFT_IR: shreg <= {tdi, shreg[IR_W-1:1]};
                default:     ;
            endcase
            if (state == TS_RESET)       ir_q <= OP_IDCODE;
            else if (state == TS_UPD_IR) ir_q <= shreg;
        end
    end

    assign ir_lsb = shreg[0];

    p_default_idcode_r2: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |=> (ir_q == OP_IDCODE));

    p_ir_hold_r3: assert property (@(posedge tck) disable iff (rst)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/bscan_tap_dr.sv
module bscan_tap_dr
    import bscan_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1BE5_7A2D
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    input  logic       rst_insn,
    input  logic       ext_rst_n,
    output logic       dr_lsb,
    output logic       core_reset
);

    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            rst_sr;
    logic            rst_hold;
    logic            cap, shf, upd;

    assign cap = (state == TS_CAP_DR);
    assign shf = (state == TS_SHIFT_DR);
    assign upd = (state == TS_UPD_DR);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q    <= 1'b0;
            id_sr    <= ID_VALUE;
            rst_sr   <= 1'b0;
            rst_hold <= 1'b0;
        end else begin
            case (sel)
                SEL_ID: begin
                    if (cap)      id_sr <= ID_VALUE;
                    else if (shf) id_sr <= {tdi, id_sr[ID_W-1:1]};
                end
                SEL_RST: begin
                    if (cap)      rst_sr <= rst_hold;
                    else if (shf) rst_sr <= tdi;
                end
                SEL_BYPASS: begin
                    if (cap)      byp_q <= 1'b0;
                    else if (shf) byp_q <= tdi;
                end
                default: ;
            endcase
            if (state == TS_RESET)      rst_hold <= 1'b0;
            else if (upd && rst_insn)   rst_hold <= rst_sr;
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_lsb = id_sr[0];
            SEL_RST: dr_lsb = rst_sr;
            default: dr_lsb = byp_q;
        endcase
    end

    assign core_reset = rst_hold | ~ext_rst_n;

    p_req_stable_r7: assert property (@(posedge tck) disable iff (rst)
        (!(upd && rst_insn) && state != TS_RESET) |=> $stable(rst_hold));

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
    import bscan_pkg::*;
#(
    parameter int NPADS = 4
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  tap_state_e       state,
    input  logic             bsr_sel,
    input  logic             extest,
    input  logic             sample,
    input  logic             core_reset,
    input  logic [NPADS-1:0] pad_in,
    input  logic [NPADS-1:0] core_out,
    input  logic [NPADS-1:0] core_oe,
    output logic             bsr_lsb,
    output logic [NPADS-1:0] pad_out,
    output logic [NPADS-1:0] pad_oe
);

    localparam int CELLS = 3;
    localparam int CHAIN = CELLS * NPADS;

    logic [CHAIN-1:0] shreg;
    logic [CHAIN-1:0] cap_img;
    logic [NPADS-1:0] sh_out, sh_oe;
    logic [NPADS-1:0] lat_out, lat_oe;

    // Per pad: input sample, output value, output enable
    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        assign cap_img[CELLS*i]     = pad_in[i];
        assign cap_img[CELLS*i + 1] = core_out[i];
        assign cap_img[CELLS*i + 2] = core_oe[i];
        assign sh_out[i]            = shreg[CELLS*i + 1];
        assign sh_oe[i]             = shreg[CELLS*i + 2];
        assign pad_out[i] = extest ? lat_out[i] : core_out[i];
        assign pad_oe[i]  = extest ? lat_oe[i]  : (core_oe[i] & ~core_reset);
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            shreg   <= '0;
            lat_out <= '0;
            lat_oe  <= '0;
        end else if (bsr_sel) begin
            if (state == TS_CAP_DR)        shreg <= cap_img;
            else if (state == TS_SHIFT_DR) shreg <= {tdi, shreg[CHAIN-1:1]};
            if (state == TS_UPD_DR) begin
                lat_out <= sh_out;
                lat_oe  <= sh_oe;
            end
        end
    end

    assign bsr_lsb = shreg[0];

    p_hiz_in_reset_r8: assert property (@(posedge tck) disable iff (rst)
        (core_reset && !extest) |-> (pad_oe == '0));

    p_preload_quiet_r5: assert property (@(posedge tck) disable iff (rst)
        (sample && !core_reset) |-> (pad_out == core_out && pad_oe == core_oe));

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import bscan_pkg::*;
#(
    parameter int              NPADS    = 4,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1BE5_7A2D
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic             ext_rst_n,
    output logic             core_reset,
    input  logic [NPADS-1:0] pad_in,
    input  logic [NPADS-1:0] core_out,
    input  logic [NPADS-1:0] core_oe,
    output logic [NPADS-1:0] pad_out,
    output logic [NPADS-1:0] pad_oe
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb, reg_lsb, bsr_lsb, dr_bit;
    ir_decode_t      dec;
    logic            in_shift_ir, in_shift_dr;

    bscan_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (tap_rst),
        .tms   (tms),
        .state (state)
    );

    bscan_tap_ir u_ir (
        .tck    (tck),
        .rst    (tap_rst),
        .tdi    (tdi),
        .state  (state),
        .ir_q   (ir_q),
        .ir_lsb (ir_lsb)
    );

    assign dec = ir_decode(ir_q);

    bscan_tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
        .tck        (tck),
        .rst        (tap_rst),
        .tdi        (tdi),
        .state      (state),
        .sel        (dec.sel),
        .rst_insn   (dec.core_rst),
        .ext_rst_n  (ext_rst_n),
        .dr_lsb     (reg_lsb),
        .core_reset (core_reset)
    );

    bscan_bsr #(.NPADS(NPADS)) u_bsr (
        .tck        (tck),
        .rst        (tap_rst),
        .tdi        (tdi),
        .state      (state),
        .bsr_sel    (dec.sel == SEL_BSR),
        .extest     (dec.extest),
        .sample     (dec.sample),
        .core_reset (core_reset),
        .pad_in     (pad_in),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .bsr_lsb    (bsr_lsb),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign in_shift_ir = (state == TS_SHIFT_IR);
    assign in_shift_dr = (state == TS_SHIFT_DR);
    assign dr_bit      = (dec.sel == SEL_BSR) ? bsr_lsb : reg_lsb;

    // Serial output launched on the falling edge
    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= in_shift_ir | in_shift_dr;
            tdo    <= in_shift_ir ? ir_lsb : (in_shift_dr ? dr_bit : 1'b0);
        end
    end

    p_tdo_window_r9: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_en == (in_shift_ir || in_shift_dr));

    p_ext_reset_r7: assert property (@(posedge tck) disable iff (tap_rst)
        !ext_rst_n |-> core_reset);

endmodule

// File: tb/test_jtag_bscan_tap.sv
module test_jtag_bscan_tap;

    localparam int          NP     = 4;
    localparam logic [31:0] EXP_ID = 32'h2468_ACE1;

    localparam logic [4:0] I_EXTEST = 5'b00000;
    localparam logic [4:0] I_SAMPLE = 5'b00010;
    localparam logic [4:0] I_CRST   = 5'b01100;
    localparam logic [4:0] I_BYPASS = 5'b11111;

    logic          tck = 1'b0;
    logic          tap_rst = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          ext_rst_n = 1'b1;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] core_out = '0;
    logic [NP-1:0] core_oe = '0;
    logic          tdo, tdo_en, core_reset;
    logic [NP-1:0] pad_out, pad_oe;

    jtag_bscan_tap #(.NPADS(NP), .ID_VALUE(EXP_ID)) i_jtag_bscan_tap (
        .tck        (tck),
        .tap_rst    (tap_rst),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_en     (tdo_en),
        .ext_rst_n  (ext_rst_n),
        .core_reset (core_reset),
        .pad_in     (pad_in),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    always #4 tck = ~tck;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    mon_on = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: each shift edge with tdo driven consumes one expected bit
    always @(posedge tck) begin
        if (mon_on && tdo_en === 1'b1) begin
            bit    e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: actual extra tdo bit %b expected none", tdo);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tdo !== e) begin
                    errors++;
                    $display("FAIL %s: actual tdo %b expected %b", t, tdo, e);
                end
            end
        end
    end

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic drain(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d bits left expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Driver: Idle -> Shift-IR -> Update-IR -> Idle
    task automatic scan_ir(input logic [4:0] op);
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(i == 0);
            tag_q.push_back("R3");
        end
        mon_on = 1'b1;
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(i == 4, op[i]);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        mon_on = 1'b0;
        drain("R3");
    endtask

    // Driver: Idle -> Shift-DR -> Update-DR -> Idle
    task automatic scan_dr(input int n, input logic [63:0] din,
                           input logic [63:0] ex, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(ex[i]);
            tag_q.push_back(tag);
        end
        mon_on = 1'b1;
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        mon_on = 1'b0;
        drain(tag);
    endtask

    function automatic logic [63:0] cap_img(input logic [NP-1:0] pin,
                                            input logic [NP-1:0] cout,
                                            input logic [NP-1:0] coe);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < NP; i++) begin
            v[3*i]     = pin[i];
            v[3*i + 1] = cout[i];
            v[3*i + 2] = coe[i];
        end
        return v;
    endfunction

    function automatic logic [63:0] load_img(input logic [NP-1:0] o, input logic [NP-1:0] e);
        return cap_img('0, o, e);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        @(negedge tck); #1;
        repeat (3) step(1'b1, 1'b0);
        tap_rst = 1'b0;
        // R10: reset state
        check("R10 tdo_en after reset", 32'(tdo_en), 32'd0);
        check("R10 core_reset after reset", 32'(core_reset), 32'd0);
        core_out = 4'b0110; core_oe = 4'b1100; pad_in = 4'b1010;
        #1;
        check("R8 pads follow core", 32'({pad_out, pad_oe}), 32'({core_out, core_oe}));

        // R2: default instruction shifts the identifier
        step(1'b0, 1'b0);
        scan_dr(32, 64'd0, 64'(EXP_ID), "R2");

        // R4: bypass delays by one bit, capture 0
        scan_ir(I_BYPASS);
        d = 64'hB2;
        scan_dr(8, d, {d[62:0], 1'b0}, "R4");
        // R3: unused opcode behaves as bypass
        scan_ir(5'b10101);
        d = 64'hC5;
        scan_dr(8, d, {d[62:0], 1'b0}, "R3");

        // R5: sample/preload capture image and quiet preload
        scan_ir(I_SAMPLE);
        scan_dr(3*NP, load_img(4'b1001, 4'b1111), cap_img(pad_in, core_out, core_oe), "R5");
        check("R5 pad_out after preload", 32'(pad_out), 32'(core_out));
        check("R5 pad_oe after preload", 32'(pad_oe), 32'(core_oe));

        // R6: external test drives pads from the preloaded latches
        scan_ir(I_EXTEST);
        check("R6 pad_out on Update-IR", 32'(pad_out), 32'h9);
        check("R6 pad_oe on Update-IR", 32'(pad_oe), 32'hF);
        pad_in = 4'b0101;
        scan_dr(3*NP, load_img(4'b0110, 4'b0011), cap_img(pad_in, core_out, core_oe), "R6");
        check("R6 pad_out after Update-DR", 32'(pad_out), 32'h6);
        check("R6 pad_oe after Update-DR", 32'(pad_oe), 32'h3);

        // R9: tdo launched on the falling edge only
        scan_ir(I_BYPASS);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        check("R9 tdo_en in Shift-DR", 32'(tdo_en), 32'd1);
        check("R9 tdo captured bypass", 32'(tdo), 32'd0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        check("R9 tdo holds after rising edge", 32'(tdo), 32'd0);
        @(negedge tck); #1;
        check("R9 tdo changes on falling edge", 32'(tdo), 32'd1);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        check("R9 tdo_en in Idle", 32'(tdo_en), 32'd0);

        // R7: reset instruction
        scan_ir(I_CRST);
        scan_dr(1, 64'd1, 64'd0, "R7");
        check("R7 core_reset set", 32'(core_reset), 32'd1);
        check("R8 pad_oe off in reset", 32'(pad_oe), 32'd0);
        scan_dr(1, 64'd1, 64'd1, "R7");
        scan_ir(I_EXTEST);
        check("R8 extest overrides reset", 32'(pad_oe), 32'h3);
        scan_ir(I_SAMPLE);
        check("R7 request survives instruction change", 32'(core_reset), 32'd1);
        check("R8 pad_oe off under sample in reset", 32'(pad_oe), 32'd0);
        scan_ir(I_CRST);
        scan_dr(1, 64'd0, 64'd1, "R7");
        check("R7 core_reset released", 32'(core_reset), 32'd0);
        check("R8 pad_oe restored", 32'(pad_oe), 32'(core_oe));
        ext_rst_n = 1'b0; #1;
        check("R7 external reset", 32'(core_reset), 32'd1);
        check("R8 pad_oe off on external reset", 32'(pad_oe), 32'd0);
        ext_rst_n = 1'b1; #1;
        check("R7 external reset released", 32'(core_reset), 32'd0);

        // R1: five mode-high edges from Shift-DR reach reset
        scan_dr(1, 64'd1, 64'd0, "R7");
        check("R1 request set before reset walk", 32'(core_reset), 32'd1);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        repeat (5) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check("R1 request cleared by Test-Logic-Reset", 32'(core_reset), 32'd0);
        scan_dr(32, 64'd0, 64'(EXP_ID), "R1");

        // R10: synchronous reset mid-scan
        scan_ir(I_BYPASS);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        tap_rst = 1'b1;
        step(1'b0, 1'b0);
        tap_rst = 1'b0;
        check("R10 tdo_en dropped", 32'(tdo_en), 32'd0);
        step(1'b0, 1'b0);
        scan_dr(32, 64'd0, 64'(EXP_ID), "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule